// File: doc/BRIEF.md
# Branch Direction Statistics Counter

This block watches a stream of resolved conditional branches and gathers direction statistics over fixed-length sampling windows. Each event presents a signed displacement and a taken flag. The block sorts the event into one of four categories: backward-taken, backward-not-taken, forward-taken or forward-not-taken. A negative displacement means backward. Zero or a positive displacement means forward. Every kind of conditional branch, including loop and counter-zero branches, is presented as one event with its own outcome.

A window counter counts every accepted event. When the event arrives that takes the window past `WINDOW_LIMIT` events, the block does three things in one cycle. It copies the four category counts, including that closing event, into snapshot registers. It pulses `report_o` for one cycle. It clears all counters, so that the next window starts from zero. The snapshot registers keep their values until the next report. Each window therefore holds `WINDOW_LIMIT + 1` events. The default limit is 10,000,000, and simulation can set it much lower.

Top module: `bds_branch_stats`

## Requirements
- R1: After synchronous reset, `report_o` is 0 and all four snapshot outputs are 0.
- R2: An event whose displacement is negative as a two's-complement number is counted as backward. A displacement of zero or above, including the largest positive value, is counted as forward.
- R3: Every accepted event increments exactly one category, so the four snapshot counts of one window sum to `WINDOW_LIMIT + 1`.
- R4: `report_o` rises in the second clock edge after the edge that samples the window's closing event, that is, the event that takes the window count past `WINDOW_LIMIT`. It does not rise earlier. The snapshot includes the closing event.
- R5: `report_o` is high for exactly one cycle per completed window.
- R6: The snapshot outputs change only in the cycle in which `report_o` is high, and hold their values between reports.
- R7: After a report, all category counts and the window count restart at zero, so the next snapshot contains only events of the next window.
- R8: An event presented in the cycle right after the closing event is counted in the new window and is not lost.
- R9: While `ev_valid_i` is low, `ev_disp_i` and `ev_taken_i` have no effect on any count.
- R10: `ev_taken_i` = 1 selects the taken category of the event's direction, and 0 selects the not-taken category.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid_i | input | 1 | A branch event is presented this cycle |
| ev_disp_i | input | DISP_W | Signed branch displacement |
| ev_taken_i | input | 1 | 1 = branch taken, 0 = not taken |
| report_o | output | 1 | One-cycle strobe: the snapshot has just been updated |
| bwd_taken_o | output | CNT_W | Snapshot: backward, taken |
| bwd_not_taken_o | output | CNT_W | Snapshot: backward, not taken |
| fwd_taken_o | output | CNT_W | Snapshot: forward, taken |
| fwd_not_taken_o | output | CNT_W | Snapshot: forward, not taken |

## Verification
Two things coincide at the window boundary. The closing event must be added to its category in the same cycle in which the counters are cleared and the snapshot is taken, and the next event is already waiting in the classifier register. The bench provokes this by holding `ev_valid_i` high across two windows with a different category in each. It judges the result by the two snapshots. If the closing event were dropped, or the next event lost or credited to the old window, the sums and the per-category values would not match, and the second report would come late or not at all.

// File: rtl/bds_pkg.sv
package bds_pkg;
  localparam int NUM_CLASS = 4;
  // category slot order used across the block
  localparam int CLS_BT = 0; // backward, taken
  localparam int CLS_BN = 1; // backward, not taken
  localparam int CLS_FT = 2; // forward, taken
  localparam int CLS_FN = 3; // forward, not taken

  function automatic logic [NUM_CLASS-1:0] class_onehot(input logic bwd, input logic taken);
    logic [NUM_CLASS-1:0] v;
    v = '0;
    if (bwd) begin
      if (taken) v[CLS_BT] = 1'b1;
      else       v[CLS_BN] = 1'b1;
    end else begin
      if (taken) v[CLS_FT] = 1'b1;
      else       v[CLS_FN] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/bds_classify.sv
module bds_classify
  import bds_pkg::*;
#(
  parameter int DISP_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic [DISP_W-1:0]    disp_i,
  input  logic                 taken_i,
  output logic [NUM_CLASS-1:0] hit_o
);
  logic                 is_bwd;
  logic [NUM_CLASS-1:0] hit_d;

  always_comb begin
    is_bwd = ($signed(disp_i) < 0);
    hit_d  = valid_i ? class_onehot(is_bwd, taken_i) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) hit_o <= '0;
    else     hit_o <= hit_d;
  end

  // R2
  sign_class_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && disp_i[DISP_W-1]) |=> (hit_o[CLS_BT] || hit_o[CLS_BN]));

  // R10
  taken_class_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && taken_i) |=> (hit_o[CLS_BT] || hit_o[CLS_FT]));

  // R9
  idle_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (hit_o == '0));
endmodule

// File: rtl/bds_counter_bank.sv
module bds_counter_bank
  import bds_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_CLASS-1:0]            hit_i,
  input  logic                            clr_i,
  output logic [NUM_CLASS-1:0][CNT_W-1:0] fin_o
);
  logic [NUM_CLASS-1:0][CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cnt
    // running total including the event currently being applied
    assign fin_o[g] = cnt_q[g] + CNT_W'(hit_i[g]);

    always_ff @(posedge clk) begin
      if (rst || clr_i)  cnt_q[g] <= '0;
      else if (hit_i[g]) cnt_q[g] <= fin_o[g];
    end
  end

  // R3
  one_category_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_i));
endmodule

// File: rtl/bds_window.sv
module bds_window #(
  parameter int WINDOW_LIMIT = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_i,
  output logic wrap_o
);
  localparam int WIN_W = (WINDOW_LIMIT < 1) ? 1 : $clog2(WINDOW_LIMIT + 1);
  localparam logic [WIN_W-1:0] LIM_V = WIN_W'(WINDOW_LIMIT);

  logic [WIN_W-1:0] win_q;

  assign wrap_o = ev_i && (win_q == LIM_V);

  always_ff @(posedge clk) begin
    if (rst || wrap_o) win_q <= '0;
    else if (ev_i)     win_q <= win_q + WIN_W'(1);
  end

  // R4
  window_bound_chk: assert property (@(posedge clk) disable iff (rst)
    win_q <= LIM_V);
endmodule

// File: rtl/bds_branch_stats.sv
module bds_branch_stats
  import bds_pkg::*;
#(
  parameter int DISP_W       = 32,
  parameter int CNT_W        = 32,
  parameter int WINDOW_LIMIT = 10_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid_i,
  input  logic [DISP_W-1:0] ev_disp_i,
  input  logic              ev_taken_i,
  output logic              report_o,
  output logic [CNT_W-1:0]  bwd_taken_o,
  output logic [CNT_W-1:0]  bwd_not_taken_o,
  output logic [CNT_W-1:0]  fwd_taken_o,
  output logic [CNT_W-1:0]  fwd_not_taken_o
);
  logic [NUM_CLASS-1:0]            hit;
  logic                            any_hit;
  logic                            wrap;
  logic [NUM_CLASS-1:0][CNT_W-1:0] fin;
  logic [NUM_CLASS-1:0][CNT_W-1:0] snap_q;

  bds_classify #(.DISP_W(DISP_W)) u_cls (
    .clk     (clk),
    .rst     (rst),
    .valid_i (ev_valid_i),
    .disp_i  (ev_disp_i),
    .taken_i (ev_taken_i),
    .hit_o   (hit)
  );

  assign any_hit = |hit;

  bds_window #(.WINDOW_LIMIT(WINDOW_LIMIT)) u_win (
    .clk    (clk),
    .rst    (rst),
    .ev_i   (any_hit),
    .wrap_o (wrap)
  );

  bds_counter_bank #(.CNT_W(CNT_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .hit_i (hit),
    .clr_i (wrap),
    .fin_o (fin)
  );

  for (genvar g = 0; g < NUM_CLASS; g++) begin : g_snap
    always_ff @(posedge clk) begin
      if (rst)       snap_q[g] <= '0;
      else if (wrap) snap_q[g] <= fin[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) report_o <= 1'b0;
    else     report_o <= wrap;
  end

  assign bwd_taken_o     = snap_q[CLS_BT];
  assign bwd_not_taken_o = snap_q[CLS_BN];
  assign fwd_taken_o     = snap_q[CLS_FT];
  assign fwd_not_taken_o = snap_q[CLS_FN];

  // R5
  report_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    report_o |=> !report_o);

  // R6
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !report_o |-> ($stable(bwd_taken_o) && $stable(bwd_not_taken_o) &&
                   $stable(fwd_taken_o) && $stable(fwd_not_taken_o)));
endmodule

// File: tb/tb_bds_branch_stats.sv
`timescale 1ns/1ps
module tb_bds_branch_stats;
  localparam int LIM = 7; // windows of 8 events

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [31:0] ev_disp = '0;
  logic        ev_taken = 1'b0;
  logic        report;
  logic [31:0] o_bt, o_bn, o_ft, o_fn;

  int tests = 0;
  int fails = 0;
  int rep_seen = 0;
  int exp_reports = 0;
  int m_cnt [4];
  int m_exp [4];
  int m_win = 0;

  always #2 clk = ~clk;

  bds_branch_stats #(.DISP_W(32), .CNT_W(32), .WINDOW_LIMIT(LIM)) dut (
    .clk             (clk),
    .rst             (rst),
    .ev_valid_i      (ev_valid),
    .ev_disp_i       (ev_disp),
    .ev_taken_i      (ev_taken),
    .report_o        (report),
    .bwd_taken_o     (o_bt),
    .bwd_not_taken_o (o_bn),
    .fwd_taken_o     (o_ft),
    .fwd_not_taken_o (o_fn)
  );

  always @(negedge clk) if (!rst && report) rep_seen++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // present one event at the current negedge and update the bench model
  task automatic drive(input logic [31:0] d, input logic t);
    int idx;
    ev_valid = 1'b1; ev_disp = d; ev_taken = t;
    idx = (d[31] ? 0 : 2) + (t ? 0 : 1);
    m_cnt[idx]++;
    m_win++;
    if (m_win > LIM) begin
      for (int k = 0; k < 4; k++) begin m_exp[k] = m_cnt[k]; m_cnt[k] = 0; end
      m_win = 0;
      exp_reports++;
    end
  endtask

  task automatic check_snap(input string tag, input int bt, input int bn, input int ft, input int fn);
    chk(o_bt == 32'(bt), {tag, " bwd_taken"}, o_bt, bt);
    chk(o_bn == 32'(bn), {tag, " bwd_not_taken"}, o_bn, bn);
    chk(o_ft == 32'(ft), {tag, " fwd_taken"}, o_ft, ft);
    chk(o_fn == 32'(fn), {tag, " fwd_not_taken"}, o_fn, fn);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(report == 1'b0, "R1 report after reset", report, 0);
    check_snap("R1", 0, 0, 0, 0);
  endtask

  // mixed signs and outcomes in one back-to-back window
  task automatic t_mixed_window();
    logic [31:0] d [8] = '{32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFEC, 32'hFFFF_FFFD,
                           32'h0, 32'd5, 32'h7FFF_FFFF, 32'd100};
    logic        t [8] = '{1, 1, 1, 0, 1, 1, 0, 0};
    for (int i = 0; i < 8; i++) begin step(); drive(d[i], t[i]); end
    step(); ev_valid = 1'b0;
    chk(report == 1'b0, "R4 no early report", report, 0);
    step();
    chk(report == 1'b1, "R4 report on closing event", report, 1);
    check_snap("R2/R3/R10", 3, 1, 2, 2);
    chk(o_bt + o_bn + o_ft + o_fn == 32'(LIM + 1), "R3 sum", o_bt + o_bn + o_ft + o_fn, LIM + 1);
    step();
    chk(report == 1'b0, "R5 strobe one cycle", report, 0);
    repeat (3) step();
    check_snap("R6 hold after report", 3, 1, 2, 2);
  endtask

  // gaps with junk on the data inputs, then the closing event
  task automatic t_gapped_window();
    step(); drive(32'hFFFF_FFF8, 1'b0);
    step(); drive(32'hFFFF_FFF8, 1'b0);
    step(); drive(32'h0, 1'b0);
    step(); drive(32'h0, 1'b0);
    for (int i = 0; i < 3; i++) begin step(); drive(32'd3, 1'b1); end
    for (int i = 0; i < 5; i++) begin
      step(); ev_valid = 1'b0; ev_disp = 32'hF000_0000 + 32'(i); ev_taken = i[0];
    end
    step();
    chk(report == 1'b0, "R9 idle cycles not counted", report, 0);
    check_snap("R6 hold mid window", 3, 1, 2, 2);
    drive(32'hFFFF_FFFF, 1'b1);
    step(); ev_valid = 1'b0;
    chk(report == 1'b0, "R4 no early report gapped", report, 0);
    step();
    chk(report == 1'b1, "R4 report gapped", report, 1);
    check_snap("R7 fresh window", m_exp[0], m_exp[1], m_exp[2], m_exp[3]);
    check_snap("R7 expected values", 1, 2, 3, 2);
  endtask

  // two windows back to back; event after closing one goes to the new window
  task automatic t_back_to_back();
    for (int i = 0; i < 16; i++) begin
      step();
      if (i == 8) chk(report == 1'b0, "R8 report timing w1", report, 0);
      if (i == 9) begin
        chk(report == 1'b1, "R8 report w1", report, 1);
        check_snap("R8 w1", 0, 0, 8, 0);
      end
      if (i < 8) drive(32'd10, 1'b1);
      else       drive(32'hFFFF_FF9C, 1'b0);
    end
    step(); ev_valid = 1'b0;
    chk(report == 1'b0, "R8 report timing w2", report, 0);
    step();
    chk(report == 1'b1, "R8 report w2", report, 1);
    check_snap("R8 w2", 0, 8, 0, 0);
    step();
    chk(rep_seen == exp_reports, "R5 report count", rep_seen, exp_reports);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_cnt[k] = 0; m_exp[k] = 0; end
    t_reset();
    t_mixed_window();
    t_gapped_window();
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule